// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for every beat of a synchronous burst read. A start strobe captures a start address together with three configuration fields: the beat order (sequential or interleaved), the window mode (wrap or no-wrap), and a burst length code for 4 words, 8 words or an unbounded run. Each pulse of the next strobe moves the burst on by one beat.

In wrap mode the burst stays inside the aligned 4- or 8-word window that holds the start address. It steps through that window either in linear order modulo the window size or in XOR (interleaved) order. In no-wrap mode, and always in continuous mode, the full address simply counts up, so the burst can cross window and bank boundaries. A valid flag marks an active burst. A last flag marks the final beat of a bounded burst.

The block only produces addresses. Latency counting, wait-state signalling and the storage array sit in neighbouring logic.

Top module: `burst_addr_gen`

## Requirements
- R1: In the cycle after `start_i` is high, `valid_o` is 1 and `addr_o` equals the `start_addr_i` value sampled at that edge. The configuration inputs are captured at the same edge and are ignored for the rest of the burst.
- R2: `len_code_i` selects the burst length: 3'b001 gives 4 beats, 3'b010 gives 8 beats and 3'b111 gives a continuous burst. Every other code gives 4 beats.
- R3: With `burst_seq_i`=1 and `no_wrap_i`=0, beat k puts ((start + k) mod L) on the low log2(L) address bits, where L is the burst length. The upper bits keep their start value.
- R4: With `burst_seq_i`=0 and `no_wrap_i`=0, beat k drives the start address with its low log2(L) bits XORed with k.
- R5: With `no_wrap_i`=1 and a 4- or 8-beat length, beat k drives start + k on the full address. `burst_seq_i` has no effect in this case.
- R6: In continuous mode beat k drives start + k on the full address, whatever `burst_seq_i` and `no_wrap_i` are. The burst crosses any boundary and never ends by itself.
- R7: `last_o` is 1 exactly on beat L-1 of a 4- or 8-beat burst, and never during a continuous burst. A `next_i` pulse on that beat clears `valid_o`.
- R8: While no burst is active, `next_i` has no effect. When `next_i` is low, `addr_o` and `valid_o` hold their values.
- R9: While `rst_ni` is low, `valid_o` is 0, `last_o` is 0 and `addr_o` is 0.
- R10: A `start_i` pulse during an active burst restarts it from the new start address and configuration at beat 0. `start_i` takes priority over `next_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a burst; captures address and configuration |
| start_addr_i | input | ADDR_W | Word address of beat 0 |
| burst_seq_i | input | 1 | 1 = sequential order, 0 = interleaved order |
| no_wrap_i | input | 1 | 1 = run past the window, 0 = wrap inside it |
| len_code_i | input | 3 | Burst length code |
| next_i | input | 1 | Advances to the next beat |
| addr_o | output | ADDR_W | Address of the current beat |
| valid_o | output | 1 | A burst is active |
| last_o | output | 1 | The current beat is the final beat |

## Verification
The assertions check on every cycle the properties that need only the previous cycle:
- loading of the start address;
- the +1 step of the linear modes;
- the frozen upper address bits in wrap mode;
- the absence of a last flag in continuous mode;
- the end of the burst after its last beat;
- holding of state when no strobe arrives.

Only the bench scenarios can show the full beat-by-beat order of the sequential-wrap and interleaved patterns, the decoding of the length codes (unlisted codes included), and a restart in the middle of a burst. The bench also shows a continuous burst running past a large address boundary.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int CNT_W = 3;  // log2 of the widest window (8 words)

  localparam logic [2:0] LC_4    = 3'b001;
  localparam logic [2:0] LC_8    = 3'b010;
  localparam logic [2:0] LC_CONT = 3'b111;

  localparam logic [CNT_W-1:0] MASK_4 = CNT_W'(3);
  localparam logic [CNT_W-1:0] MASK_8 = CNT_W'(7);
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_addr_pkg::*;
(
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] mask_o,
  output logic             cont_o
);
  always_comb begin
    mask_o = MASK_4;
    cont_o = 1'b0;
    unique case (code_i)
      LC_8:    mask_o = MASK_8;
      LC_CONT: begin
        mask_o = MASK_8;
        cont_o = 1'b1;
      end
      default: mask_o = MASK_4;  // LC_4 and every unlisted code
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_addr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             next_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  assign last_o  = valid_q && !cont_i && (cnt_q == mask_i);
  assign cnt_o   = cnt_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (valid_q && next_i) begin
      if (last_o)       valid_q <= 1'b0;
      else if (!cont_i) cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] lin_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  mask_i,
  input  logic              seq_i,
  input  logic              wrap_i,
  input  logic              cont_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] cnt_ext, mask_ext, seq_addr, ilv_addr;

  assign cnt_ext  = {{PAD_W{1'b0}}, cnt_i};
  assign mask_ext = {{PAD_W{1'b0}}, mask_i};
  assign seq_addr = (base_i & ~mask_ext) | ((base_i + cnt_ext) & mask_ext);
  assign ilv_addr = base_i ^ cnt_ext;

  always_comb begin
    if (cont_i || !wrap_i) addr_o = lin_i;
    else if (seq_i)        addr_o = seq_addr;
    else                   addr_o = ilv_addr;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              burst_seq_i,
  input  logic              no_wrap_i,
  input  logic [2:0]        len_code_i,
  input  logic              next_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] base_q, lin_q;
  logic [CNT_W-1:0]  mask_d, mask_q, cnt;
  logic              cont_d, cont_q, seq_q, wrap_q;

  burst_len_decode u_dec (
    .code_i (len_code_i),
    .mask_o (mask_d),
    .cont_o (cont_d)
  );

  // configuration is captured once per burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      lin_q  <= '0;
      mask_q <= MASK_4;
      cont_q <= 1'b0;
      seq_q  <= 1'b1;
      wrap_q <= 1'b1;
    end else if (start_i) begin
      base_q <= start_addr_i;
      lin_q  <= start_addr_i;
      mask_q <= mask_d;
      cont_q <= cont_d;
      seq_q  <= burst_seq_i;
      wrap_q <= !no_wrap_i;
    end else if (valid_o && next_i && !last_o) begin
      lin_q  <= lin_q + 1'b1;
    end
  end

  burst_beat_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .next_i  (next_i),
    .cont_i  (cont_q),
    .mask_i  (mask_q),
    .cnt_o   (cnt),
    .valid_o (valid_o),
    .last_o  (last_o)
  );

  burst_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .base_i (base_q),
    .lin_i  (lin_q),
    .cnt_i  (cnt),
    .mask_i (mask_q),
    .seq_i  (seq_q),
    .wrap_i (wrap_q),
    .cont_i (cont_q),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              next_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              last_o,
  input logic [CNT_W-1:0]  mask_q,
  input logic              cont_q,
  input logic              wrap_q
);
  logic [ADDR_W-1:0] hi_mask;
  logic              step;

  assign hi_mask = ~{{(ADDR_W-CNT_W){1'b0}}, mask_q};
  assign step    = valid_o && next_i && !start_i && !last_o;

  assert_start_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && addr_o == $past(start_addr_i));

  assert_wrap_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && wrap_q && !cont_q |=> (addr_o & hi_mask) == ($past(addr_o) & $past(hi_mask)));

  assert_linear_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && (!wrap_q || cont_q) |=> addr_o == $past(addr_o) + 1'b1);

  assert_no_last_cont_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_q |-> !last_o);

  assert_burst_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && next_i && last_o && !start_i |=> !valid_o);

  assert_last_in_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !(valid_o && next_i) |=> $stable(addr_o) && $stable(valid_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .next_i       (next_i),
  .addr_o       (addr_o),
  .valid_o      (valid_o),
  .last_o       (last_o),
  .mask_q       (mask_q),
  .cont_q       (cont_q),
  .wrap_q       (wrap_q)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          seq = 1'b1;
  logic          nw = 1'b0;
  logic [2:0]    code = 3'b001;
  logic          nxt = 1'b0;
  logic [AW-1:0] addr;
  logic          valid, last;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .start_addr_i (start_addr),
    .burst_seq_i (seq), .no_wrap_i (nw), .len_code_i (code), .next_i (nxt),
    .addr_o (addr), .valid_o (valid), .last_o (last)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int beats(input logic [2:0] c);
    if (c == 3'b010) return 8;
    if (c == 3'b111) return 0;
    return 4;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic s,
                                              input logic w, input logic [2:0] c, input int k);
    int            l = beats(c);
    logic [AW-1:0] m = AW'(l - 1);
    if (l == 0 || w) return b + AW'(k);
    if (s) return (b & ~m) | ((b + AW'(k)) & m);
    return b ^ AW'(k);
  endfunction

  task automatic begin_burst(input logic [AW-1:0] b, input logic s, input logic w, input logic [2:0] c);
    @(negedge clk);
    start = 1'b1; start_addr = b; seq = s; nw = w; code = c;
    @(negedge clk);
    start = 1'b0;
    // scramble config to show it was captured at start
    seq = ~s; nw = ~w; code = 3'b000; start_addr = ~b;
  endtask

  task automatic step();
    nxt = 1'b1;
    @(negedge clk);
    nxt = 1'b0;
  endtask

  // walks n beats checking address, valid and last
  task automatic walk(input string req, input logic [AW-1:0] b, input logic s,
                      input logic w, input logic [2:0] c, input int n);
    int l = beats(c);
    for (int k = 0; k < n; k++) begin
      chk({req, " addr"}, addr, exp_addr(b, s, w, c, k));
      chk({req, " valid"}, AW'(valid), AW'(1));
      chk({req, " last R7"}, AW'(last), AW'(l != 0 && k == l - 1));
      step();
    end
  endtask

  task automatic t_reset();
    chk("R9 valid", AW'(valid), '0);
    chk("R9 last", AW'(last), '0);
    chk("R9 addr", addr, '0);
  endtask

  task automatic t_seq_wrap();
    begin_burst(24'h00000D, 1'b1, 1'b0, 3'b001);
    chk("R1 load", addr, 24'h00000D);
    walk("R3 seq4", 24'h00000D, 1'b1, 1'b0, 3'b001, 4);
    chk("R7 end", AW'(valid), '0);
    chk("R7 last clear", AW'(last), '0);
    begin_burst(24'h001005, 1'b1, 1'b0, 3'b010);
    walk("R3 seq8", 24'h001005, 1'b1, 1'b0, 3'b010, 8);
    chk("R2 len8 end", AW'(valid), '0);
  endtask

  task automatic t_interleave();
    begin_burst(24'h002006, 1'b0, 1'b0, 3'b010);
    walk("R4 ilv8", 24'h002006, 1'b0, 1'b0, 3'b010, 8);
    begin_burst(24'h00ABC9, 1'b0, 1'b0, 3'b001);
    walk("R4 ilv4", 24'h00ABC9, 1'b0, 1'b0, 3'b001, 4);
    chk("R4 end", AW'(valid), '0);
  endtask

  task automatic t_nowrap();
    begin_burst(24'h003006, 1'b0, 1'b1, 3'b010);
    walk("R5 nowrap8 ilv", 24'h003006, 1'b0, 1'b1, 3'b010, 8);
    chk("R5 end", AW'(valid), '0);
    begin_burst(24'h00403E, 1'b1, 1'b1, 3'b001);
    walk("R5 nowrap4 seq", 24'h00403E, 1'b1, 1'b1, 3'b001, 4);
  endtask

  task automatic t_cont();
    begin_burst(24'h00FFFB, 1'b0, 1'b0, 3'b111);
    walk("R6 cont", 24'h00FFFB, 1'b0, 1'b0, 3'b111, 20);
    chk("R6 still valid", AW'(valid), AW'(1));
  endtask

  task automatic t_codes();
    begin_burst(24'h000102, 1'b1, 1'b0, 3'b000);
    walk("R2 code000", 24'h000102, 1'b1, 1'b0, 3'b000, 4);
    chk("R2 code000 end", AW'(valid), '0);
    begin_burst(24'h000207, 1'b0, 1'b0, 3'b011);
    walk("R2 code011", 24'h000207, 1'b0, 1'b0, 3'b011, 4);
    chk("R2 code011 end", AW'(valid), '0);
  endtask

  task automatic t_hold_idle();
    logic [AW-1:0] held;
    begin_burst(24'h000501, 1'b1, 1'b0, 3'b010);
    step(); step();
    held = addr;
    repeat (3) @(negedge clk);
    chk("R8 hold addr", addr, held);
    chk("R8 hold addr value", addr, 24'h000503);
    repeat (6) step();  // beats 2..7
    chk("R8 ended", AW'(valid), '0);
    held = addr;
    step(); step();
    chk("R8 idle next valid", AW'(valid), '0);
    chk("R8 idle next addr", addr, held);
  endtask

  task automatic t_restart();
    begin_burst(24'h000700, 1'b1, 1'b0, 3'b001);
    step();
    @(negedge clk);
    start = 1'b1; nxt = 1'b1; start_addr = 24'h000A16; seq = 1'b0; nw = 1'b0; code = 3'b010;
    @(negedge clk);
    start = 1'b0; nxt = 1'b0; code = 3'b001;
    chk("R10 restart addr", addr, 24'h000A16);
    walk("R10 restart ilv8", 24'h000A16, 1'b0, 1'b0, 3'b010, 8);
    chk("R10 end", AW'(valid), '0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_seq_wrap();
    t_interleave();
    t_nowrap();
    t_cont();
    t_codes();
    t_hold_idle();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule